// File: doc/BRIEF.md
# SPI Slave Command and FIFO Port

This block lets an external host reach a device over a four-wire SPI link running in mode 0 (clock idles low, data sampled on the rising edge, MSB first, chip select active low). Each transaction opens with a command byte. The top three bits of that byte pick one of two kinds of access. The first is a 16-bit control register, moved as two bytes with the high byte first. The second is a burst of bytes into or out of a pair of 32-entry FIFOs. The receive FIFO collects bytes that the host writes, and the device drains it. The transmit FIFO is filled by the device and drained by host reads.

All SPI pins are resynchronised into the system clock. SCLK is oversampled, so shifting happens on the detected edges of the synchronised clock. A small register set holds the receive and transmit thresholds, a five-bit status word describing the receive FIFO, a per-bit interrupt enable mask, a write-one-to-clear port and the live occupancy of both FIFOs. The interrupt request is high whenever an enabled status bit is set.

Top module: `spis_top`

## Requirements
- R1: Bits are shifted MSB first. MOSI is taken on each rising SCLK edge. MISO changes only after falling edges and presents the MSB of each reply byte before that byte's first rising edge. While no reply is due, MISO is 0.
- R2: Command bits [7:5] select the operation: 000 register read, 001 register write, 011 FIFO read, 101 FIFO write. Every other code has no effect on registers or FIFOs, and MISO stays 0 for the whole transaction.
- R3: Register commands take the address from bits [4:1]. A read returns the 16-bit value (high byte, then low byte) in the two bytes after the command, and a write takes the value from those two bytes. Address 0 holds the thresholds, with bits [11:6] for transmit and [5:0] for receive; bits [15:12] read 0. Address 2 holds the enable mask in bits [4:0]. Unmapped addresses read 0.
- R4: After a FIFO write command with count field n in bits [4:0] (n=0 means 32), the next n bytes are pushed into the receive FIFO. Further bytes in the same transaction are ignored.
- R5: After a FIFO read command with count n (n=0 means 32), each of the next n bytes pops the transmit FIFO, or returns 0x00 if it is empty. Later bytes return 0x00 and pop nothing.
- R6: Address 4 reads the receive count in bits [11:6] and the transmit count in bits [5:0].
- R7: Status (address 1) bit 4 is set while the receive FIFO is non-empty, bit 2 while its count exceeds the receive threshold, bit 1 while it is empty, and bit 0 while its count is below the receive threshold. Each bit stays set until it is cleared.
- R8: A FIFO-write byte that arrives when the receive FIFO holds 32 entries is dropped and sets status bit 3. That bit stays set until it is cleared.
- R9: Writing address 3 clears every status bit written as 1. A bit whose condition still holds is set again on the next cycle. Address 3 reads 0.
- R10: irq_o is high exactly when some status bit and its enable bit are both 1.
- R11: Raising CS_n abandons the current command, including a partly received byte. The next falling CS_n starts a new command byte.
- R12: rx_valid_o and rx_data_o show the head of the receive FIFO, and rx_pop_i removes it. tx_push_i appends tx_data_i unless tx_full_o is set, in which case the push is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk_i | input | 1 | SPI serial clock from the host |
| spi_cs_n_i | input | 1 | SPI chip select, active low |
| spi_mosi_i | input | 1 | Host-to-device serial data |
| spi_miso_o | output | 1 | Device-to-host serial data |
| rx_valid_o | output | 1 | Receive FIFO holds at least one byte |
| rx_data_o | output | 8 | Head byte of the receive FIFO |
| rx_pop_i | input | 1 | Remove the head of the receive FIFO |
| tx_push_i | input | 1 | Append tx_data_i to the transmit FIFO |
| tx_data_i | input | 8 | Byte to append |
| tx_full_o | output | 1 | Transmit FIFO holds 32 bytes |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions assume that every SCLK level lasts several system clocks. This lets each synchronised edge be handled before the next one arrives and before CS_n moves. They also assume that MOSI and CS_n change only while SCLK is low. The stimulus holds each SCLK phase for six system clocks, sets MOSI half a period before each rising edge, and moves CS_n only with SCLK low and a full phase away from any edge. Device-side pops and pushes are single-cycle pulses driven between system clock edges.

// File: rtl/spis_pkg.sv
package spis_pkg;
    // Operation codes carried in command bits [7:5]
    typedef enum logic [2:0] {
        OP_RD_REG  = 3'b000,
        OP_WR_REG  = 3'b001,
        OP_RD_FIFO = 3'b011,
        OP_WR_FIFO = 3'b101
    } spis_op_e;

    localparam int FLD_W = 6;   // width of a threshold or count field
    localparam int STS_W = 5;   // status, enable and clear width

    // Register addresses
    localparam logic [3:0] A_THR = 4'd0;
    localparam logic [3:0] A_STS = 4'd1;
    localparam logic [3:0] A_EN  = 4'd2;
    localparam logic [3:0] A_CLR = 4'd3;
    localparam logic [3:0] A_CNT = 4'd4;
endpackage

// File: rtl/spis_sync.sv
module spis_sync #(
    parameter int             W       = 1,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= RST_VAL;
            q      <= RST_VAL;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end
endmodule

// File: rtl/spis_fifo.sv
module spis_fifo #(
    parameter  int DW    = 8,
    parameter  int DEPTH = 32,              // power of two
    localparam int AW    = $clog2(DEPTH),
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [DW-1:0] wdata,
    input  logic          pop,
    output logic [DW-1:0] rdata,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty
);
    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [CW-1:0] cnt;
    } fifo_st_t;

    fifo_st_t      q, d;
    logic [DW-1:0] mem [DEPTH];
    logic          push_ok, pop_ok;

    assign full  = (q.cnt == CW'(DEPTH));
    assign empty = (q.cnt == '0);
    assign count = q.cnt;
    assign rdata = mem[q.rp];

    always_comb begin
        d       = q;
        push_ok = push && !full;
        pop_ok  = pop && !empty;
        if (push_ok) d.wp = q.wp + AW'(1);
        if (pop_ok)  d.rp = q.rp + AW'(1);
        d.cnt = q.cnt + CW'(push_ok) - CW'(pop_ok);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem[q.wp] <= wdata;
    end

    // R12: occupancy never exceeds the depth
    p_count_bound_r12: assert property (@(posedge clk) disable iff (!rst_n)
        q.cnt <= CW'(DEPTH));

    // R8: a push into a full FIFO without a pop leaves it full and unchanged
    p_drop_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop) |=> (full && $stable(q.wp)));
endmodule

// File: rtl/spis_top.sv
module spis_top
    import spis_pkg::*;
#(
    parameter  int FIFO_DEPTH = 32,
    localparam int CW         = $clog2(FIFO_DEPTH + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       spi_sclk_i,
    input  logic       spi_cs_n_i,
    input  logic       spi_mosi_i,
    output logic       spi_miso_o,
    output logic       rx_valid_o,
    output logic [7:0] rx_data_o,
    input  logic       rx_pop_i,
    input  logic       tx_push_i,
    input  logic [7:0] tx_data_i,
    output logic       tx_full_o,
    output logic       irq_o
);
    typedef struct packed {
        logic             sclk_prev;
        logic [2:0]       bitcnt;
        logic [1:0]       bytecnt;   // saturates at 3
        logic [2:0]       op;
        logic [3:0]       addr;
        logic [6:0]       sh_in;
        logic [7:0]       tx_sh;
        logic [7:0]       tx_nxt;
        logic             load;
        logic [3:0]       hi;
        logic [7:0]       rd_lo;
        logic [CW-1:0]    remain;
        logic [11:0]      thr;
        logic [STS_W-1:0] en;
        logic [STS_W-1:0] sts;
    } top_st_t;

    top_st_t q, d;

    logic          sclk_s, cs_s, mosi_s;
    logic          rise, fall, done;
    logic [7:0]    byte_in;
    logic [15:0]   rd_val;
    logic          rx_push, rx_full, rx_empty;
    logic          tx_pop, tx_empty;
    logic [7:0]    tx_rdata;
    logic [CW-1:0] rx_cnt, tx_cnt, n_val;
    logic [FLD_W-1:0] rx_lvl;
    logic [STS_W-1:0] clr, cond;

    spis_sync #(.W(3), .RST_VAL(3'b010)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .d({spi_sclk_i, spi_cs_n_i, spi_mosi_i}),
        .q({sclk_s, cs_s, mosi_s})
    );

    spis_fifo #(.DW(8), .DEPTH(FIFO_DEPTH)) u_rxf (
        .clk(clk), .rst_n(rst_n),
        .push(rx_push), .wdata(byte_in), .pop(rx_pop_i),
        .rdata(rx_data_o), .count(rx_cnt), .full(rx_full), .empty(rx_empty)
    );

    spis_fifo #(.DW(8), .DEPTH(FIFO_DEPTH)) u_txf (
        .clk(clk), .rst_n(rst_n),
        .push(tx_push_i), .wdata(tx_data_i), .pop(tx_pop),
        .rdata(tx_rdata), .count(tx_cnt), .full(tx_full_o), .empty(tx_empty)
    );

    assign rise    = sclk_s && !q.sclk_prev;
    assign fall    = !sclk_s && q.sclk_prev;
    assign done    = rise && (q.bitcnt == 3'd7);
    assign byte_in = {q.sh_in, mosi_s};
    assign rx_lvl  = FLD_W'(rx_cnt);
    assign n_val   = (byte_in[4:0] == 5'd0) ? CW'(FIFO_DEPTH) : CW'(byte_in[4:0]);

    // Register read mux, addressed by the command byte being completed
    always_comb begin
        case (byte_in[4:1])
            A_THR:   rd_val = {4'b0, q.thr};
            A_STS:   rd_val = {{(16-STS_W){1'b0}}, q.sts};
            A_EN:    rd_val = {{(16-STS_W){1'b0}}, q.en};
            A_CNT:   rd_val = {4'b0, rx_lvl, FLD_W'(tx_cnt)};
            default: rd_val = 16'h0000;
        endcase
    end

    always_comb begin
        d           = q;
        rx_push     = 1'b0;
        tx_pop      = 1'b0;
        clr         = '0;
        d.sclk_prev = sclk_s;
        if (cs_s) begin
            d.bitcnt  = '0;
            d.bytecnt = '0;
            d.load    = 1'b0;
            d.tx_sh   = '0;
            d.remain  = '0;
        end else begin
            if (rise) begin
                d.sh_in  = byte_in[6:0];
                d.bitcnt = q.bitcnt + 3'd1;
            end
            if (fall) begin
                if (q.load) begin
                    d.tx_sh = q.tx_nxt;
                    d.load  = 1'b0;
                end else begin
                    d.tx_sh = {q.tx_sh[6:0], 1'b0};
                end
            end
            if (done) begin
                d.load   = 1'b1;
                d.tx_nxt = 8'h00;
                if (q.bytecnt != 2'd3) d.bytecnt = q.bytecnt + 2'd1;
                if (q.bytecnt == 2'd0) begin
                    d.op   = byte_in[7:5];
                    d.addr = byte_in[4:1];
                    case (byte_in[7:5])
                        OP_RD_REG: begin
                            d.tx_nxt = rd_val[15:8];
                            d.rd_lo  = rd_val[7:0];
                        end
                        OP_RD_FIFO: begin
                            tx_pop   = 1'b1;
                            d.tx_nxt = tx_empty ? 8'h00 : tx_rdata;
                            d.remain = n_val - CW'(1);
                        end
                        OP_WR_FIFO: d.remain = n_val;
                        default: ;
                    endcase
                end else begin
                    case (q.op)
                        OP_RD_REG: if (q.bytecnt == 2'd1) d.tx_nxt = q.rd_lo;
                        OP_WR_REG: begin
                            if (q.bytecnt == 2'd1) d.hi = byte_in[3:0];
                            else if (q.bytecnt == 2'd2) begin
                                case (q.addr)
                                    A_THR:   d.thr = {q.hi, byte_in};
                                    A_EN:    d.en  = byte_in[STS_W-1:0];
                                    A_CLR:   clr   = byte_in[STS_W-1:0];
                                    default: ;
                                endcase
                            end
                        end
                        OP_RD_FIFO: if (q.remain != '0) begin
                            tx_pop   = 1'b1;
                            d.tx_nxt = tx_empty ? 8'h00 : tx_rdata;
                            d.remain = q.remain - CW'(1);
                        end
                        OP_WR_FIFO: if (q.remain != '0) begin
                            rx_push  = 1'b1;
                            d.remain = q.remain - CW'(1);
                        end
                        default: ;
                    endcase
                end
            end
        end
        cond  = {!rx_empty, rx_push && rx_full, rx_lvl > q.thr[5:0],
                 rx_empty, rx_lvl < q.thr[5:0]};
        d.sts = (q.sts & ~clr) | cond;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign spi_miso_o = q.tx_sh[7];
    assign rx_valid_o = !rx_empty;
    assign irq_o      = |(q.sts & q.en);

    // R11: with chip select high, MISO is driven low
    p_miso_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        cs_s |=> !spi_miso_o);

    // R8: overflow status survives every cycle without a clear of that bit
    p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (q.sts[3] && !clr[3]) |=> q.sts[3]);

    // R7: an empty receive FIFO sets the empty status bit on the next cycle
    p_empty_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_cnt == '0) |=> q.sts[1]);

    // R2: a single command never pushes and pops in the same cycle
    p_push_pop_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rx_push, tx_pop}));
endmodule

// File: tb/tb_spis_top.sv
`timescale 1ns/1ps
module tb_spis_top;
    localparam int DEPTH = 32;
    localparam int HP    = 30;   // SCLK half period in ns (six system clocks)

    logic clk = 1'b0, rst_n = 1'b0;
    logic sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
    logic miso, rx_valid, tx_full, irq;
    logic [7:0] rx_data;
    logic rx_pop = 1'b0, tx_push = 1'b0;
    logic [7:0] tx_data = 8'h00;

    int nchk = 0, nfail = 0;
    bit cmp_en = 1'b0;
    bit finished = 1'b0;

    // behavioural reference state
    logic [7:0]  rxq[$];
    logic [7:0]  txq[$];
    logic [11:0] m_thr = '0;
    logic [4:0]  m_en = '0, m_sts = '0;

    always #2.5 clk = ~clk;

    spis_top dut (
        .clk(clk), .rst_n(rst_n),
        .spi_sclk_i(sclk), .spi_cs_n_i(cs_n), .spi_mosi_i(mosi), .spi_miso_o(miso),
        .rx_valid_o(rx_valid), .rx_data_o(rx_data), .rx_pop_i(rx_pop),
        .tx_push_i(tx_push), .tx_data_i(tx_data), .tx_full_o(tx_full),
        .irq_o(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic void m_upd();
        int c = rxq.size();
        if (c > 0)            m_sts[4] = 1'b1;
        if (c > int'(m_thr[5:0])) m_sts[2] = 1'b1;
        if (c == 0)           m_sts[1] = 1'b1;
        if (c < int'(m_thr[5:0])) m_sts[0] = 1'b1;
    endfunction

    function automatic logic [15:0] m_reg(input logic [3:0] a);
        case (a)
            4'd0: return {4'b0, m_thr};
            4'd1: return {11'b0, m_sts};
            4'd2: return {11'b0, m_en};
            4'd4: return {4'b0, 6'(rxq.size()), 6'(txq.size())};
            default: return 16'h0000;
        endcase
    endfunction

    // idle-time comparison against the reference on every clock
    always @(negedge clk) begin
        if (cmp_en) begin
            chk("R10 irq", irq, |(m_sts & m_en));
            chk("R12 rx_valid", rx_valid, rxq.size() != 0);
            if (rxq.size() != 0) chk("R12 rx_data", rx_data, rxq[0]);
            chk("R12 tx_full", tx_full, txq.size() == DEPTH);
            chk("R1 miso idle", miso, 1'b0);
        end
    end

    task automatic spi_byte(input logic [7:0] o, output logic [7:0] i);
        for (int b = 7; b >= 0; b--) begin
            mosi = o[b];
            #(HP);
            i[b] = miso;
            sclk = 1'b1;
            #(HP);
            sclk = 1'b0;
        end
    endtask

    task automatic x_begin();
        cmp_en = 1'b0;
        cs_n = 1'b0;
        #(HP);
    endtask

    task automatic x_end();
        #(HP);
        cs_n = 1'b1;
        repeat (8) @(negedge clk);
        cmp_en = 1'b1;
    endtask

    task automatic reg_rd(input logic [3:0] a, output logic [15:0] v);
        logic [7:0] x, h, l;
        x_begin();
        spi_byte({3'b000, a, 1'b1}, x);
        spi_byte(8'h00, h);
        spi_byte(8'h00, l);
        x_end();
        v = {h, l};
    endtask

    task automatic reg_wr(input logic [3:0] a, input logic [15:0] v);
        logic [7:0] x;
        x_begin();
        spi_byte({3'b001, a, 1'b1}, x);
        spi_byte(v[15:8], x);
        spi_byte(v[7:0], x);
        x_end();
        case (a)
            4'd0: m_thr = v[11:0];
            4'd2: m_en  = v[4:0];
            4'd3: m_sts = m_sts & ~v[4:0];
            default: ;
        endcase
        m_upd();
    endtask

    task automatic fifo_wr(input logic [4:0] n, input int send, input logic [7:0] base);
        logic [7:0] x;
        int nn = (n == 0) ? DEPTH : int'(n);
        x_begin();
        spi_byte({3'b101, n}, x);
        for (int k = 0; k < send; k++) begin
            spi_byte(base + 8'(k), x);
            if (k < nn) begin
                if (rxq.size() < DEPTH) rxq.push_back(base + 8'(k));
                else m_sts[3] = 1'b1;
            end
            m_upd();
        end
        x_end();
    endtask

    task automatic fifo_rd(input logic [4:0] n, input int send);
        logic [7:0] x, exp;
        int nn = (n == 0) ? DEPTH : int'(n);
        x_begin();
        spi_byte({3'b011, n}, x);
        chk("R1 miso during command byte", x, 8'h00);
        for (int k = 0; k < send; k++) begin
            spi_byte(8'hFF, x);
            exp = 8'h00;
            if (k < nn && txq.size() != 0) exp = txq.pop_front();
            chk("R5 fifo read byte", x, exp);
        end
        x_end();
    endtask

    task automatic dev_pop(input int cnt);
        cmp_en = 1'b0;
        for (int k = 0; k < cnt; k++) begin
            @(negedge clk);
            chk("R12 rx head before pop", rx_data, rxq[0]);
            rx_pop = 1'b1;
            @(negedge clk);
            rx_pop = 1'b0;
            void'(rxq.pop_front());
            m_upd();
        end
        repeat (4) @(negedge clk);
        cmp_en = 1'b1;
    endtask

    task automatic dev_push(input logic [7:0] v);
        cmp_en = 1'b0;
        @(negedge clk);
        tx_push = 1'b1;
        tx_data = v;
        @(negedge clk);
        tx_push = 1'b0;
        if (txq.size() < DEPTH) txq.push_back(v);
        repeat (2) @(negedge clk);
        cmp_en = 1'b1;
    endtask

    initial begin
        #1_000_000;
        if (!finished) begin
            nchk++;
            nfail++;
            $display("FAIL watchdog expired before R1..R12 sequence completed");
            $display("%0d/%0d checks passed", nchk - nfail, nchk);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        logic [7:0]  x;
        repeat (4) @(negedge clk);
        chk("R10 irq in reset", irq, 1'b0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        chk("R1 miso after reset", miso, 1'b0);
        chk("R12 rx_valid after reset", rx_valid, 1'b0);
        m_upd();
        cmp_en = 1'b1;

        // R7 reset status: only empty is set
        reg_rd(4'd1, v);
        chk("R7 status after reset", v, 16'h0002);

        // R3 threshold register width and readback
        reg_wr(4'd0, 16'hFFFF);
        reg_rd(4'd0, v);
        chk("R3 threshold upper bits read 0", v, 16'h0FFF);
        reg_wr(4'd0, 16'h00C3);
        reg_rd(4'd0, v);
        chk("R3 threshold readback", v, 16'h00C3);
        reg_rd(4'd3, v);
        chk("R9 clear register reads 0", v, 16'h0000);
        reg_rd(4'd7, v);
        chk("R3 unmapped address", v, 16'h0000);
        reg_wr(4'd2, 16'h0010);
        reg_rd(4'd2, v);
        chk("R3 enable readback", v, 16'h0010);

        // R4 FIFO write with exact and surplus byte counts
        fifo_wr(5'd2, 2, 8'hA0);
        chk("R10 irq on not-empty", irq, 1'b1);
        fifo_wr(5'd3, 5, 8'hB0);
        reg_rd(4'd4, v);
        chk("R4 R6 count after limited write", v, 16'h0140);
        reg_rd(4'd1, v);
        chk("R7 status accumulated", v, m_reg(4'd1));
        chk("R7 status literal", v, 16'h0017);

        // R9 clear with conditions still true
        reg_wr(4'd3, 16'h001F);
        reg_rd(4'd1, v);
        chk("R9 status after clear", v, 16'h0014);
        dev_pop(2);
        reg_wr(4'd3, 16'h0004);
        reg_rd(4'd1, v);
        chk("R9 R7 over-threshold cleared at count 3", v, 16'h0010);

        // R10 masking
        reg_wr(4'd2, 16'h0000);
        chk("R10 irq masked", irq, 1'b0);
        reg_wr(4'd2, 16'h0010);
        chk("R10 irq unmasked", irq, 1'b1);

        // R5 FIFO reads
        dev_push(8'h11); dev_push(8'h22); dev_push(8'h33);
        reg_rd(4'd4, v);
        chk("R6 both counts", v, 16'h00C3);
        fifo_rd(5'd2, 2);
        fifo_rd(5'd1, 2);
        fifo_rd(5'd0, 2);
        dev_push(8'h44); dev_push(8'h55);
        fifo_rd(5'd1, 2);
        reg_rd(4'd4, v);
        chk("R5 surplus byte pops nothing", v, m_reg(4'd4));
        fifo_rd(5'd1, 1);

        // R8 overflow on a full receive FIFO
        fifo_wr(5'd0, 32, 8'hC0);
        reg_rd(4'd1, v);
        chk("R8 overflow bit set", v[3], 1'b1);
        chk("R8 status vs model", v, m_reg(4'd1));
        dev_pop(DEPTH);
        reg_rd(4'd1, v);
        chk("R8 overflow sticky after drain", v[3], 1'b1);
        reg_wr(4'd3, 16'h0008);
        reg_rd(4'd1, v);
        chk("R8 R9 overflow cleared", v[3], 1'b0);

        // R2 unused operation codes
        x_begin();
        spi_byte(8'hE3, x);
        spi_byte(8'h5A, x);
        chk("R2 miso zero for unused code", x, 8'h00);
        spi_byte(8'h5A, x);
        chk("R2 miso zero for unused code second byte", x, 8'h00);
        x_end();
        x_begin();
        spi_byte(8'h45, x);
        spi_byte(8'hA5, x);
        spi_byte(8'hA5, x);
        x_end();
        reg_rd(4'd4, v);
        chk("R2 counts unchanged by unused codes", v, m_reg(4'd4));
        reg_rd(4'd2, v);
        chk("R2 enable unchanged by unused codes", v, 16'h0010);

        // R11 abort mid-command and mid-byte
        x_begin();
        spi_byte({3'b001, 4'd2, 1'b1}, x);
        spi_byte(8'hFF, x);
        x_end();
        reg_rd(4'd2, v);
        chk("R11 aborted write leaves enable", v, 16'h0010);
        x_begin();
        for (int b = 0; b < 4; b++) begin
            mosi = 1'b1; #(HP); sclk = 1'b1; #(HP); sclk = 1'b0;
        end
        x_end();
        reg_rd(4'd0, v);
        chk("R11 fresh command after partial byte", v, 16'h00C3);

        // R12 transmit FIFO full and ignored push
        for (int k = 0; k < DEPTH; k++) dev_push(8'(8'h60 + k));
        chk("R12 tx_full at depth", tx_full, 1'b1);
        dev_push(8'hEE);
        reg_rd(4'd4, v);
        chk("R12 R6 tx count capped", v, m_reg(4'd4));
        fifo_rd(5'd0, 33);
        chk("R12 tx_full released", tx_full, 1'b0);

        finished = 1'b1;
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end
endmodule